// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable down-counting timer. Software, through a bus decoder outside the block, writes a 16-bit initial count, a 3-bit operating mode and a binary/decimal select with a single load strobe. After that, the channel counts down on each cycle in which the count-enable tick is asserted. It produces an output waveform whose shape depends on the mode, and it shows its live count value.

Six modes are offered. Mode 0 raises the output after a terminal count. Mode 1 is a one-shot that a gate edge retriggers. Mode 2 is a rate generator. Mode 3 is a square-wave generator. Mode 4 gives a single strobe started by software. Mode 5 gives a single strobe started by the gate. The gate input either pauses counting or restarts it from the initial count, depending on the mode. The count register can run in plain binary or in four-digit packed BCD, where the decrement borrows digit by digit.

Top module: `interval_counter_ch`

## Requirements
- R1: A loaded initial count of 0 behaves as the largest count: 65536 ticks in binary and 10000 ticks in BCD. A tick on value 0 gives FFFF (binary) or 9999 (BCD).
- R2: When `bcd_i`=1 at load, each decrement borrows per decimal digit, so for example 0010 becomes 0009 and 0000 becomes 9999.
- R3: In modes 0, 1, 4 and 5 the counter does not stop at zero. It wraps to FFFF or 9999 and keeps counting.
- R4: In mode 2 (`mode_i`=2) the count runs N, N-1, ..., 1 and then reloads N on the tick that ends the period. `out_o` is high for exactly the one clock after that tick, and it is not high right after the load.
- R5: In mode 3 (`mode_i`=3) the count reloads like mode 2. `out_o` is high for the first (N+1)/2 ticks of every period of N ticks and low for the rest.
- R6: In mode 0, `out_o` is low after the load. It goes high in the clock after the Nth tick and stays high until the next load.
- R7: In modes 4 and 5, `out_o` is high for one clock after the tick that brings the count to 0. It does not pulse again on later wraps until the next load or trigger.
- R8: In mode 1, `out_o` is high after the load. It goes low when the gate trigger arrives and high again after N ticks.
- R9: In modes 0, 2, 3 and 4, ticks while `gate_i` is low do not change the count.
- R10: A rising edge on `gate_i` reloads the initial count in modes 1, 2, 3 and 5. In modes 1 and 5 the count does not move after a load until such an edge arrives.
- R11: Mode values 6 and 7 behave as modes 2 and 3.
- R12: After reset, `count_o` is 0 and `out_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable tick, one decrement per asserted cycle |
| gate_i | input | 1 | Gate level; a rising edge is a trigger |
| load_i | input | 1 | Load strobe for count, mode and number base |
| load_val_i | input | 16 | Initial count (0 means maximum) |
| mode_i | input | 3 | Operating mode 0..7 |
| bcd_i | input | 1 | 1 = packed BCD counting, 0 = binary |
| out_o | output | 1 | Mode-dependent output waveform |
| count_o | output | 16 | Current count value |

## Verification
The bench builds the channel with its default of four digits, so the counter is the full 16 bits. Because ticks can be driven on every cycle, a zero load runs through its complete 65536-tick binary period and 10000-tick decimal period within the run. That reaches the reload boundary after the full wrap, not only the short periods. Small counts of 1 to 10 cover the square-wave halves for odd and even periods, as well as the pulse-every-tick case of a rate period of one.

// File: rtl/ic_pkg.sv
package ic_pkg;

  typedef enum logic [2:0] {
    MD_TERM   = 3'd0,
    MD_ONESHT = 3'd1,
    MD_RATE   = 3'd2,
    MD_SQUARE = 3'd3,
    MD_SWSTB  = 3'd4,
    MD_HWSTB  = 3'd5
  } ic_mode_e;

  // values 6 and 7 fold onto rate and square (R11)
  function automatic ic_mode_e fold_mode(input logic [2:0] m);
    if (m[2:1] == 2'b11) return ic_mode_e'({1'b0, m[1:0]});
    return ic_mode_e'(m);
  endfunction

  function automatic logic is_gate_started(input ic_mode_e m);
    return (m == MD_ONESHT) || (m == MD_HWSTB);
  endfunction

  function automatic logic is_periodic(input ic_mode_e m);
    return (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

endpackage

// File: rtl/ic_edge.sv
module ic_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/ic_step.sv
module ic_step #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val_i,
  input  logic                bcd_i,
  output logic [4*DIGITS-1:0] dec_o,
  output logic                last_o
);
  localparam int W = 4 * DIGITS;

  function automatic logic [W-1:0] dec_bcd(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic         borrow;
    r      = v;
    borrow = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (borrow) begin
        if (v[4*i +: 4] == 4'd0) begin
          r[4*i +: 4] = 4'd9;
        end else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          borrow      = 1'b0;
        end
      end
    end
    return r;
  endfunction

  assign dec_o  = bcd_i ? dec_bcd(val_i) : (val_i - {{(W-1){1'b0}}, 1'b1});
  assign last_o = (val_i == {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/ic_wave.sv
module ic_wave
  import ic_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  ic_mode_e            mode_i,
  input  logic                bcd_i,
  input  logic [4*DIGITS-1:0] cnt_i,
  input  logic [4*DIGITS-1:0] init_i,
  input  logic                armed_i,
  input  logic                done_i,
  input  logic                pulse_i,
  output logic                out_o
);
  localparam int W  = 4 * DIGITS;
  localparam int TW = W + 1;

  function automatic logic [TW-1:0] pow10(input int n);
    logic [TW-1:0] p;
    p = TW'(1);
    for (int i = 0; i < n; i++) p = p * TW'(10);
    return p;
  endfunction

  localparam logic [TW-1:0] DEC_MAX = pow10(DIGITS);
  localparam logic [TW-1:0] BIN_MAX = TW'(1) << W;

  // number of ticks a register value stands for; 0 is the full range
  function automatic logic [TW-1:0] ticks_of(input logic [W-1:0] v, input logic b);
    logic [TW-1:0] acc;
    if (v == '0) return b ? DEC_MAX : BIN_MAX;
    if (!b) return TW'(v);
    acc = '0;
    for (int i = DIGITS - 1; i >= 0; i--)
      acc = acc * TW'(10) + TW'(v[4*i +: 4]);
    return acc;
  endfunction

  logic sq_high;
  assign sq_high = ticks_of(cnt_i, bcd_i) > (ticks_of(init_i, bcd_i) >> 1);

  always_comb begin
    unique case (mode_i)
      MD_TERM, MD_ONESHT:           out_o = done_i;
      MD_RATE, MD_SWSTB, MD_HWSTB:  out_o = pulse_i;
      MD_SQUARE:                    out_o = armed_i & sq_high;
      default:                      out_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/interval_counter_ch.sv
module interval_counter_ch
  import ic_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                gate_i,
  input  logic                load_i,
  input  logic [4*DIGITS-1:0] load_val_i,
  input  logic [2:0]          mode_i,
  input  logic                bcd_i,
  output logic                out_o,
  output logic [4*DIGITS-1:0] count_o
);
  localparam int W = 4 * DIGITS;

  ic_mode_e     mode_q;
  logic         bcd_q;
  logic [W-1:0] init_q;
  logic [W-1:0] cnt_q;
  logic         armed_q;
  logic         done_q;
  logic         fired_q;
  logic         pulse_q;

  // named internal events
  logic         gate_rise;
  logic         restart;
  logic         step_en;
  logic [W-1:0] cnt_dec;
  logic         at_last;
  ic_mode_e     load_mode;

  ic_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate_i),
    .rise_o (gate_rise)
  );

  ic_step #(.DIGITS(DIGITS)) u_step (
    .val_i  (cnt_q),
    .bcd_i  (bcd_q),
    .dec_o  (cnt_dec),
    .last_o (at_last)
  );

  assign load_mode = fold_mode(mode_i);
  assign restart   = !load_i && gate_rise && (mode_q != MD_TERM) && (mode_q != MD_SWSTB);
  assign step_en   = !load_i && !restart && tick_i && armed_q
                     && (gate_i || is_gate_started(mode_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MD_TERM;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      fired_q <= 1'b0;
      pulse_q <= 1'b0;
    end else if (load_i) begin
      mode_q  <= load_mode;
      bcd_q   <= bcd_i;
      init_q  <= load_val_i;
      cnt_q   <= load_val_i;
      armed_q <= !is_gate_started(load_mode);
      done_q  <= (load_mode == MD_ONESHT);
      fired_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (restart) begin
        cnt_q   <= init_q;
        armed_q <= 1'b1;
        fired_q <= 1'b0;
        if (mode_q == MD_ONESHT) done_q <= 1'b0;
      end else if (step_en) begin
        if (is_periodic(mode_q) && at_last) begin
          cnt_q   <= init_q;
          pulse_q <= (mode_q == MD_RATE);
        end else begin
          cnt_q <= cnt_dec;
        end
        if (at_last) begin
          if (mode_q == MD_TERM || mode_q == MD_ONESHT) done_q <= 1'b1;
          if ((mode_q == MD_SWSTB || mode_q == MD_HWSTB) && !fired_q) begin
            pulse_q <= 1'b1;
            fired_q <= 1'b1;
          end
        end
      end
    end
  end

  ic_wave #(.DIGITS(DIGITS)) u_wave (
    .mode_i  (mode_q),
    .bcd_i   (bcd_q),
    .cnt_i   (cnt_q),
    .init_i  (init_q),
    .armed_i (armed_q),
    .done_i  (done_q),
    .pulse_i (pulse_q),
    .out_o   (out_o)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/ic_checker.sv
module ic_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         load_i,
  input logic         out_o,
  input logic [W-1:0] count_o,
  input logic [2:0]   mode_q,
  input logic         bcd_q,
  input logic         step_en,
  input logic         gate_rise
);
  localparam logic [W-1:0] ALL_NINES = {(W/4){4'h9}};

  // R4 R7: a strobe in the pulse modes only follows a tick
  p_pulse_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd2 || mode_q == 3'd4 || mode_q == 3'd5) && out_o) |-> $past(tick_i));

  // R9: without tick, load or trigger the count holds
  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i && !gate_rise) |=> $stable(count_o));

  // R6: terminal output is sticky until a load
  p_term_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && out_o && !load_i) |=> out_o);

  // R2: decimal zero steps to all nines
  p_bcd_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && bcd_q && count_o == '0) |=> (count_o == ALL_NINES));

  // R11: the held mode never takes an alias value
  p_mode_folded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (mode_q < 3'd6));
endmodule

bind interval_counter_ch ic_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .load_i    (load_i),
  .out_o     (out_o),
  .count_o   (count_o),
  .mode_q    (mode_q),
  .bcd_q     (bcd_q),
  .step_en   (step_en),
  .gate_rise (gate_rise)
);

// File: tb/tb_interval_counter_ch.sv
module tb_interval_counter_ch;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b1;
  logic        load_i = 1'b0;
  logic [15:0] load_val_i = '0;
  logic [2:0]  mode_i = '0;
  logic        bcd_i = 1'b0;
  logic        out_o;
  logic [15:0] count_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  interval_counter_ch dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .gate_i     (gate_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .mode_i     (mode_i),
    .bcd_i      (bcd_i),
    .out_o      (out_o),
    .count_o    (count_o)
  );

  // {req[3:0], mode[2:0], bcd, value[15:0], ticks[7:0], exp_count[15:0], exp_out}
  localparam logic [48:0] VEC [NV] = '{
    {4'd6,  3'd0, 1'b0, 16'h0005, 8'd3,  16'h0002, 1'b0},  // R6 before terminal
    {4'd6,  3'd0, 1'b0, 16'h0005, 8'd5,  16'h0000, 1'b1},  // R6 terminal reached
    {4'd3,  3'd0, 1'b0, 16'h0005, 8'd7,  16'hFFFE, 1'b1},  // R3 wrap keeps counting
    {4'd2,  3'd0, 1'b1, 16'h0003, 8'd5,  16'h9998, 1'b1},  // R2 decimal wrap
    {4'd4,  3'd2, 1'b0, 16'h0004, 8'd3,  16'h0001, 1'b0},  // R4 no pulse yet
    {4'd4,  3'd2, 1'b0, 16'h0004, 8'd4,  16'h0004, 1'b1},  // R4 reload + pulse
    {4'd4,  3'd2, 1'b0, 16'h0004, 8'd5,  16'h0003, 1'b0},  // R4 pulse ends
    {4'd5,  3'd3, 1'b0, 16'h0005, 8'd0,  16'h0005, 1'b1},  // R5 high at start
    {4'd5,  3'd3, 1'b0, 16'h0005, 8'd2,  16'h0003, 1'b1},  // R5 still high
    {4'd5,  3'd3, 1'b0, 16'h0005, 8'd3,  16'h0002, 1'b0},  // R5 low half
    {4'd5,  3'd3, 1'b0, 16'h0005, 8'd5,  16'h0005, 1'b1},  // R5 new period
    {4'd7,  3'd4, 1'b0, 16'h0003, 8'd3,  16'h0000, 1'b1},  // R7 strobe
    {4'd7,  3'd4, 1'b0, 16'h0003, 8'd4,  16'hFFFF, 1'b0},  // R7 strobe once
    {4'd11, 3'd6, 1'b0, 16'h0004, 8'd4,  16'h0004, 1'b1},  // R11 6 as rate
    {4'd11, 3'd7, 1'b0, 16'h0004, 8'd2,  16'h0002, 1'b0},  // R11 7 as square
    {4'd5,  3'd3, 1'b1, 16'h0010, 8'd4,  16'h0006, 1'b1},  // R5 decimal high
    {4'd5,  3'd3, 1'b1, 16'h0010, 8'd5,  16'h0005, 1'b0},  // R5 decimal low
    {4'd2,  3'd2, 1'b1, 16'h0010, 8'd10, 16'h0010, 1'b1},  // R2 decimal period
    {4'd1,  3'd0, 1'b0, 16'h0000, 8'd1,  16'hFFFF, 1'b0},  // R1 zero is max
    {4'd4,  3'd2, 1'b0, 16'h0001, 8'd3,  16'h0001, 1'b1}   // R4 period of one
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [2:0] m, input logic b, input logic [15:0] v);
    load_i = 1'b1; mode_i = m; bcd_i = b; load_val_i = v;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  task automatic trigger();
    gate_i = 1'b0;
    @(negedge clk);
    gate_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 count", count_o, 16'h0000);
    chk("R12 out", {15'd0, out_o}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [48:0] v;
      v = VEC[k];
      load(v[44:42], v[41], v[40:25]);
      ticks(int'(v[24:17]));
      chk($sformatf("R%0d vec%0d count", v[48:45], k), count_o, v[16:1]);
      chk($sformatf("R%0d vec%0d out", v[48:45], k), {15'd0, out_o}, {15'd0, v[0]});
    end

    // R1 binary zero load: full 65536 tick period in rate mode
    load(3'd2, 1'b0, 16'h0000);
    ticks(65535);
    chk("R1 bin before end count", count_o, 16'h0001);
    chk("R1 bin before end out", {15'd0, out_o}, 16'd0);
    ticks(1);
    chk("R1 bin period count", count_o, 16'h0000);
    chk("R1 bin period out", {15'd0, out_o}, 16'd1);

    // R1 decimal zero load: full 10000 tick period
    load(3'd2, 1'b1, 16'h0000);
    ticks(9999);
    chk("R1 bcd before end count", count_o, 16'h0001);
    ticks(1);
    chk("R1 bcd period count", count_o, 16'h0000);
    chk("R1 bcd period out", {15'd0, out_o}, 16'd1);

    // R9 gate low pauses mode 0 and mode 4
    load(3'd0, 1'b0, 16'h0005);
    gate_i = 1'b0;
    ticks(3);
    chk("R9 mode0 paused", count_o, 16'h0005);
    gate_i = 1'b1;
    ticks(2);
    chk("R9 mode0 resumed", count_o, 16'h0003);
    load(3'd4, 1'b0, 16'h0003);
    gate_i = 1'b0;
    ticks(2);
    chk("R9 mode4 paused", count_o, 16'h0003);
    gate_i = 1'b1;
    @(negedge clk);

    // R8 R10 one-shot
    load(3'd1, 1'b0, 16'h0003);
    chk("R8 idle out", {15'd0, out_o}, 16'd1);
    ticks(2);
    chk("R10 waits for trigger", count_o, 16'h0003);
    trigger();
    chk("R8 trigger out", {15'd0, out_o}, 16'd0);
    ticks(2);
    chk("R8 mid count", count_o, 16'h0001);
    chk("R8 mid out", {15'd0, out_o}, 16'd0);
    ticks(1);
    chk("R8 end out", {15'd0, out_o}, 16'd1);
    ticks(1);
    chk("R3 mode1 wraps", count_o, 16'hFFFF);
    trigger();
    chk("R10 retrigger count", count_o, 16'h0003);
    chk("R10 retrigger out", {15'd0, out_o}, 16'd0);

    // R7 R10 hardware strobe
    load(3'd5, 1'b0, 16'h0002);
    ticks(3);
    chk("R10 mode5 waits", count_o, 16'h0002);
    trigger();
    ticks(2);
    chk("R7 mode5 count", count_o, 16'h0000);
    chk("R7 mode5 strobe", {15'd0, out_o}, 16'd1);
    ticks(1);
    chk("R7 mode5 wraps", count_o, 16'hFFFF);
    chk("R7 mode5 strobe ends", {15'd0, out_o}, 16'd0);
    trigger();
    ticks(2);
    chk("R7 mode5 strobe after retrigger", {15'd0, out_o}, 16'd1);

    // R10 rate generator restarted by gate edge
    load(3'd2, 1'b0, 16'h0005);
    ticks(2);
    chk("R10 rate before restart", count_o, 16'h0003);
    trigger();
    chk("R10 rate restart", count_o, 16'h0005);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule